// File: doc/BRIEF.md
# Frame Capture Sequencer

This block is the top-level control state machine of a camera capture path, running in the 50 MHz system clock domain. It runs one capture cycle at a time. After reset it spends a fixed number of cycles initializing and then waits for a go command. It then waits for the start of a frame, reads pixels out of the clock-crossing FIFO for as long as the frame lasts, and counts them. Once the frame ends it writes exactly that many words to a USB FIFO interface. Last, it polls for a pending host command and either halts or starts the next frame.

Pixels come from a 27 MHz sensor domain through a dual-clock FIFO that sits outside this block. The frame-sync input is asynchronous to this block and is synchronized here. Capture and transfer never overlap, and the count taken during capture fixes the length of the transfer that follows. The states are INIT (0), IDLE (1), ARM (2, waiting for frame start), GRAB (3, capture), SEND (4, transfer) and POLL (5, command check). The transitions are INIT→IDLE when the init timer expires, IDLE→ARM on go, ARM→GRAB on a rising synchronized frame sync, GRAB→SEND when the synchronized frame sync is low, SEND→POLL when all words are sent, POLL→IDLE when a command is pending, and POLL→ARM otherwise.

Top module: `frame_capture_seq`

## Requirements
- R1: While reset is asserted and directly after it, `state_o` is 0 (INIT), both strobes are low and `pixel_count_o` is 0. After INIT_CYCLES clock edges the state becomes 1 (IDLE).
- R2: In IDLE (1) the state holds while `go_i` is low. A cycle with `go_i` high moves the state to ARM (2) on the next edge.
- R3: `vsync_i` passes through a SYNC_STAGES-flop synchronizer (default 2). In ARM (2) a rising edge of the synchronized level moves the state to GRAB (3). Outside GRAB, `fifo_rd_o` stays low and the count does not change, whatever `pix_avail_i` does.
- R4: In GRAB, every cycle with `pix_avail_i` high (and the count below its maximum) drives `fifo_rd_o` high, and `pixel_count_o` rises by one on that edge.
- R5: GRAB ends on the edge on which the synchronized frame sync is seen low, which is the third edge after `vsync_i` falls. A pixel that is available in that exit cycle is still read and counted. The state then becomes SEND (4).
- R6: The pixel count stops at 2^CNT_W−1. At that value `fifo_rd_o` stays low even while pixels are available.
- R7: In SEND, `usb_wr_o` is high only in cycles where `usb_full_i` is low. A full cycle stalls the transfer and no word is lost.
- R8: SEND issues exactly `pixel_count_o` writes. On the edge after the last one (or at once if the count is 0), the count clears to 0 and the state becomes POLL (5).
- R9: POLL lasts one cycle. It moves to IDLE (1) if `cmd_pending_i` is high, otherwise to ARM (2).
- R10: `fifo_rd_o` and `usb_wr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Start command, acted on only in IDLE |
| vsync_i | input | 1 | Asynchronous frame sync, high during a frame |
| pix_avail_i | input | 1 | Crossing FIFO holds at least one pixel |
| usb_full_i | input | 1 | USB FIFO cannot take a word |
| cmd_pending_i | input | 1 | Host command waiting, sampled in POLL |
| fifo_rd_o | output | 1 | Read strobe to the crossing FIFO |
| usb_wr_o | output | 1 | Write strobe to the USB FIFO |
| pixel_count_o | output | CNT_W | Pixels captured in the current frame |
| state_o | output | 3 | Current state code (0 to 5, as listed above) |

## Verification
Two events can fall in the same cycle: reading a pixel and recognizing the end of the frame. The bench provokes this by keeping `pix_avail_i` high while it drops `vsync_i`. It judges the result by the count the design reports in SEND, which must equal the pixels driven during the frame plus the three cycles the synchronizer needs, exit cycle included. It then checks that the transfer sends exactly that many words. A zero-length frame, where SEND is entered and left in the same cycle, and a frame that runs into count saturation are also checked.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        ST_INIT = 3'd0,
        ST_IDLE = 3'd1,
        ST_ARM  = 3'd2,
        ST_GRAB = 3'd3,
        ST_SEND = 3'd4,
        ST_POLL = 3'd5
    } fcs_state_e;

endpackage

// File: rtl/fcs_vsync_sync.sv
module fcs_vsync_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/fcs_counters.sv
module fcs_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_pix_i,
    input  logic             inc_sent_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] pix_cnt_o,
    output logic             pix_max_o,
    output logic             all_sent_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] pix_q;
    logic [CNT_W-1:0] sent_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pix_q  <= '0;
            sent_q <= '0;
        end else begin
            if (inc_pix_i)  pix_q  <= pix_q + 1'b1;
            if (inc_sent_i) sent_q <= sent_q + 1'b1;
        end
    end

    assign pix_cnt_o  = pix_q;
    assign pix_max_o  = (pix_q == CNT_MAX);
    assign all_sent_o = (sent_q == pix_q);

endmodule

// File: rtl/frame_capture_seq.sv
module frame_capture_seq
    import fcs_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int INIT_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             vsync_i,
    input  logic             pix_avail_i,
    input  logic             usb_full_i,
    input  logic             cmd_pending_i,
    output logic             fifo_rd_o,
    output logic             usb_wr_o,
    output logic [CNT_W-1:0] pixel_count_o,
    output logic [2:0]       state_o
);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);

    fcs_state_e        state_q, state_d;
    logic [INIT_W-1:0] init_q;
    logic              init_done;
    logic              vs_level, vs_rise;
    logic              pix_max, all_sent, cnt_clr;

    fcs_vsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (vsync_i),
        .level_o (vs_level),
        .rise_o  (vs_rise)
    );

    fcs_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_pix_i  (fifo_rd_o),
        .inc_sent_i (usb_wr_o),
        .clr_i      (cnt_clr),
        .pix_cnt_o  (pixel_count_o),
        .pix_max_o  (pix_max),
        .all_sent_o (all_sent)
    );

    // Initialization timer, runs only in INIT
    always_ff @(posedge clk) begin
        if (!rst_n)                 init_q <= '0;
        else if (state_q == ST_INIT) init_q <= init_q + 1'b1;
    end
    assign init_done = (init_q == INIT_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: if (init_done) state_d = ST_IDLE;
            ST_IDLE: if (go_i)      state_d = ST_ARM;
            ST_ARM:  if (vs_rise)   state_d = ST_GRAB;
            ST_GRAB: if (!vs_level) state_d = ST_SEND;
            ST_SEND: if (all_sent)  state_d = ST_POLL;
            ST_POLL: state_d = cmd_pending_i ? ST_IDLE : ST_ARM;
            default: state_d = ST_INIT;
        endcase
    end

    // Outputs
    always_comb begin
        fifo_rd_o = 1'b0;
        usb_wr_o  = 1'b0;
        cnt_clr   = 1'b0;
        unique case (state_q)
            ST_GRAB: fifo_rd_o = pix_avail_i & ~pix_max;
            ST_SEND: begin
                usb_wr_o = ~usb_full_i & ~all_sent;
                cnt_clr  = all_sent;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go_i,
    input logic             usb_full_i,
    input logic             cmd_pending_i,
    input logic             fifo_rd_o,
    input logic             usb_wr_o,
    input logic [CNT_W-1:0] pixel_count_o,
    input logic [2:0]       state_o
);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !go_i) |=> state_o == 3'd1);

    assert_rd_in_grab_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |-> state_o == 3'd3);

    assert_rd_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |=> pixel_count_o == $past(pixel_count_o) + 1'b1);

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pixel_count_o == {CNT_W{1'b1}}) |-> !fifo_rd_o);

    assert_wr_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        usb_wr_o |-> (!usb_full_i && state_o == 3'd4));

    assert_poll_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd5 |-> pixel_count_o == '0);

    assert_poll_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd5 |=> state_o == (cmd_pending_i ? 3'd1 : 3'd2) || !$past(rst_n));

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_rd_o && usb_wr_o));

endmodule

bind frame_capture_seq fcs_checker #(.CNT_W(CNT_W)) u_fcs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .go_i          (go_i),
    .usb_full_i    (usb_full_i),
    .cmd_pending_i (cmd_pending_i),
    .fifo_rd_o     (fifo_rd_o),
    .usb_wr_o      (usb_wr_o),
    .pixel_count_o (pixel_count_o),
    .state_o       (state_o)
);

// File: tb/test_frame_capture_seq.sv
module test_frame_capture_seq;
    localparam int CNT_W = 4;
    localparam int INIT_CYCLES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0, vsync = 1'b0, pix = 1'b0, full = 1'b0, cmd = 1'b0;
    logic rd, wr;
    logic [CNT_W-1:0] cnt;
    logic [2:0] st;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frame_capture_seq #(.CNT_W(CNT_W), .INIT_CYCLES(INIT_CYCLES), .SYNC_STAGES(2)) i_frame_capture_seq (
        .clk(clk), .rst_n(rst_n), .go_i(go), .vsync_i(vsync), .pix_avail_i(pix),
        .usb_full_i(full), .cmd_pending_i(cmd), .fifo_rd_o(rd), .usb_wr_o(wr),
        .pixel_count_o(cnt), .state_o(st)
    );

    typedef struct packed {
        logic [7:0] npix;
        logic [7:0] exp;
        logic [7:0] mask;
        logic       cmd;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'd5,  8'd5,  8'h00,        1'b0},
        '{8'd7,  8'd7,  8'b1011_0010, 1'b0},
        '{8'd0,  8'd0,  8'hFF,        1'b0},
        '{8'd20, 8'd15, 8'b0101_0101, 1'b0},
        '{8'd4,  8'd4,  8'b1100_1100, 1'b1}
    };

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            finish_run();
        end
    end

    task automatic wait_state(input logic [2:0] s);
        while (st != s) @(negedge clk);
    endtask

    // Starts at a negedge in SEND; counts writes under a cyclic full pattern
    task automatic run_send(input logic [7:0] mask, input int exp, input logic c);
        int writes = 0;
        int k = 0;
        bit bad = 1'b0;
        cmd = c;
        while (st == 3'd4) begin
            full = mask[k % 8];
            #1;
            if (wr) writes++;
            if (full && wr) bad = 1'b1;
            k++;
            @(negedge clk);
        end
        full = 1'b0;
        chk("R7 no write while full", !bad, bad, 0);
        chk("R8 words sent equal count", writes == exp, writes, exp);
        chk("R8 enters POLL", st == 3'd5, st, 5);
        chk("R8 count cleared", cnt == 0, cnt, 0);
        @(negedge clk);
        chk("R9 POLL exit", st == (c ? 3'd1 : 3'd2), st, c ? 1 : 2);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset state", st == 3'd0 && !rd && !wr && cnt == 0, st, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 INIT after reset", st == 3'd0, st, 0);
        repeat (INIT_CYCLES) @(negedge clk);
        chk("R1 reaches IDLE", st == 3'd1, st, 1);
        repeat (5) @(negedge clk);
        chk("R2 IDLE holds without go", st == 3'd1, st, 1);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk("R2 go moves to ARM", st == 3'd2, st, 2);

        // R3 pixels ignored in ARM
        pix = 1'b1;
        #1;
        chk("R3 no read in ARM", !rd, rd, 0);
        repeat (3) @(negedge clk);
        chk("R3 count unchanged in ARM", cnt == 0 && st == 3'd2, cnt, 0);
        pix = 1'b0;

        // Vector table: one frame per entry
        foreach (VEC[i]) begin
            wait_state(3'd2);
            vsync = 1'b1;
            wait_state(3'd3);
            pix = 1'b1;
            repeat (int'(VEC[i].npix)) @(negedge clk);
            pix = 1'b0;
            vsync = 1'b0;
            wait_state(3'd4);
            chk("R4 R6 captured count", cnt == VEC[i].exp, cnt, VEC[i].exp);
            run_send(VEC[i].mask, int'(VEC[i].exp), VEC[i].cmd);
        end

        // Last vector left the sequencer in IDLE: restart
        chk("R9 halted in IDLE", st == 3'd1, st, 1);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;

        // R5 pixel available in the same cycle the frame ends
        vsync = 1'b1;
        wait_state(3'd3);
        pix = 1'b1;
        repeat (4) @(negedge clk);
        vsync = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 still in GRAB two cycles after vsync fall", st == 3'd3, st, 3);
        @(negedge clk);
        pix = 1'b0;
        chk("R5 in SEND on third edge", st == 3'd4, st, 4);
        chk("R5 exit-cycle pixel counted", cnt == 7, cnt, 7);
        run_send(8'b0000_0110, 7, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule